// File: doc/BRIEF.md
# UART Receive Character Queue with Bypass

This block sits between a UART receiver's shift logic and the host read path. Each time the receiver finishes a character, it presents the byte and three per-character error flags with a one-cycle write strobe. The block stores them as one entry. The host sees the oldest entry on a show-ahead read port and removes it with a read strobe. Status outputs report empty, full, a sticky overrun flag, a one-cycle overrun event and the current fill level.

A mode input chooses between queue operation at the full depth and holding-register operation. In holding-register mode the block reports full as soon as one character is held. A second character arriving before the first is read raises overrun. The storage array is never switched off, though. The extra character is still placed behind the first, provided the array has room, and the host has to read it out before the block reports empty again. The mode may change at any time, and stored entries are kept across the change.

Top module: `uart_rx_queue`

## Requirements
- R1: After asynchronous reset, level_o is 0, empty_o is 1, full_o is 0, overrun_o is 0 and ovr_evt_o is 0.
- R2: rd_word_o shows the oldest stored entry in the layout {break, parity, framing, data[7:0]}, that is bit 10 = break, bit 9 = parity, bit 8 = framing and bits 7:0 = data. A read strobe on a non-empty block removes that entry, and entries leave in arrival order.
- R3: With fifo_en_i = 1, full_o is 1 exactly when DEPTH (16 by default) entries are held. A write while full is discarded and raises overrun, even if a read happens in the same cycle.
- R4: With fifo_en_i = 0, full_o is 1 whenever at least one entry is held. A write in that state raises overrun, and the character is still stored if fewer than DEPTH entries are held, so it must be read out later.
- R5: overrun_o goes to 1 in the cycle after an overrun write and stays 1 until ovr_clr_i is pulsed. A clear in the same cycle as an overrun write leaves overrun_o at 0.
- R6: ovr_evt_o is a one-cycle pulse in the cycle after each overrun write, and it fires even when a clear occurs in that same cycle.
- R7: level_o counts the held entries from 0 to DEPTH. A read and an accepted write in the same cycle leave level_o unchanged.
- R8: A read strobe while empty is ignored: level_o stays 0. While empty, rd_word_o is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_en_i | input | 1 | 1 = queue mode, 0 = holding-register mode |
| wr_i | input | 1 | Character-complete strobe from the receiver |
| wr_data_i | input | 8 | Received byte |
| wr_frm_i | input | 1 | Framing error flag for this character |
| wr_par_i | input | 1 | Parity error flag for this character |
| wr_brk_i | input | 1 | Break flag for this character |
| rd_i | input | 1 | Host read strobe that removes the oldest entry |
| ovr_clr_i | input | 1 | Overrun clear strobe |
| rd_word_o | output | 11 | Oldest entry {break, parity, framing, data} |
| empty_o | output | 1 | No entries held |
| full_o | output | 1 | Full for the current mode |
| overrun_o | output | 1 | Sticky overrun flag |
| ovr_evt_o | output | 1 | One-cycle overrun event |
| level_o | output | 5 | Number of held entries |

## Verification
The bench builds the block with its default DEPTH of 16. At that size it fills the array completely, so it can reach a discarded write at the array limit, a read and a write together at the limit, and the clear-versus-set collision. The same instance then switches to holding-register mode. That puts a second character behind the first and shows that the extra character must be drained.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int unsigned RXQ_DATA_W = 8;

  typedef struct packed {
    logic                  brk;
    logic                  par;
    logic                  frm;
    logic [RXQ_DATA_W-1:0] data;
  } rxq_entry_t;

  localparam int unsigned RXQ_ENTRY_W = $bits(rxq_entry_t);
endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       push_i,
  input  logic       pop_i,
  input  rxq_entry_t wdata_i,
  output rxq_entry_t head_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  rxq_entry_t    mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      if (push_i) wr_ptr_q <= nxt(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= nxt(rd_ptr_q);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_ptr_q] <= wdata_i;
  end

  assign head_o = mem_q[rd_ptr_q];
endmodule

// File: rtl/rxq_level.sv
module rxq_level #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  output logic [CW-1:0] level_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_o <= '0;
    end else begin
      unique case ({push_i, pop_i})
        2'b10:   level_o <= level_o + CW'(1);
        2'b01:   level_o <= level_o - CW'(1);
        default: level_o <= level_o;
      endcase
    end
  end
endmodule

// File: rtl/rxq_ovr.sv
module rxq_ovr (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic clr_i,
  output logic overrun_o,
  output logic evt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      overrun_o <= 1'b0;
      evt_o     <= 1'b0;
    end else begin
      evt_o <= hit_i;
      // clear wins over a same-cycle set
      if (clr_i)      overrun_o <= 1'b0;
      else if (hit_i) overrun_o <= 1'b1;
    end
  end
endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   fifo_en_i,
  input  logic                   wr_i,
  input  logic [RXQ_DATA_W-1:0]  wr_data_i,
  input  logic                   wr_frm_i,
  input  logic                   wr_par_i,
  input  logic                   wr_brk_i,
  input  logic                   rd_i,
  input  logic                   ovr_clr_i,
  output logic [RXQ_ENTRY_W-1:0] rd_word_o,
  output logic                   empty_o,
  output logic                   full_o,
  output logic                   overrun_o,
  output logic                   ovr_evt_o,
  output logic [CW-1:0]          level_o
);
  localparam logic [CW-1:0] CAP = CW'(DEPTH);

  rxq_entry_t wentry, head;
  logic       arr_full, push, pop, hit;

  assign wentry   = '{brk: wr_brk_i, par: wr_par_i, frm: wr_frm_i, data: wr_data_i};
  assign empty_o  = (level_o == '0);
  assign arr_full = (level_o == CAP);
  // holding-register mode reports full at one entry; array is still used
  assign full_o   = fifo_en_i ? arr_full : !empty_o;
  assign push     = wr_i && !arr_full;
  assign pop      = rd_i && !empty_o;
  assign hit      = wr_i && full_o;

  rxq_store #(.DEPTH(DEPTH)) i_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (push),
    .pop_i  (pop),
    .wdata_i(wentry),
    .head_o (head)
  );

  rxq_level #(.DEPTH(DEPTH)) i_level (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (push),
    .pop_i  (pop),
    .level_o(level_o)
  );

  rxq_ovr i_ovr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hit_i    (hit),
    .clr_i    (ovr_clr_i),
    .overrun_o(overrun_o),
    .evt_o    (ovr_evt_o)
  );

  assign rd_word_o = empty_o ? '0 : head;
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          fifo_en_i,
  input logic          wr_i,
  input logic          rd_i,
  input logic          ovr_clr_i,
  input logic          empty_o,
  input logic          full_o,
  input logic          overrun_o,
  input logic          ovr_evt_o,
  input logic [CW-1:0] level_o
);
  localparam logic [CW-1:0] CAP = CW'(DEPTH);

  a_r7_level_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= CAP);

  a_r7_rw_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && rd_i && !empty_o && level_o != CAP) |=> $stable(level_o));

  a_r3_no_grow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_en_i && full_o && wr_i && !rd_i) |=> (level_o == CAP));

  a_r4_hold_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fifo_en_i && !empty_o) |-> full_o);

  a_r5_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_o && !ovr_clr_i) |=> overrun_o);

  a_r5_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_clr_i |=> !overrun_o);

  a_r6_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && full_o) |=> ovr_evt_o);

  a_r8_empty_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && rd_i && !wr_i) |=> empty_o);
endmodule

bind uart_rx_queue rxq_checker #(.DEPTH(DEPTH)) i_rxq_checker (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .fifo_en_i(fifo_en_i),
  .wr_i     (wr_i),
  .rd_i     (rd_i),
  .ovr_clr_i(ovr_clr_i),
  .empty_o  (empty_o),
  .full_o   (full_o),
  .overrun_o(overrun_o),
  .ovr_evt_o(ovr_evt_o),
  .level_o  (level_o)
);

// File: tb/test_uart_rx_queue.sv
`timescale 1ns/1ps
module test_uart_rx_queue;
  localparam int unsigned DEPTH = 16;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic          clk_i = 1'b0;
  logic          rst_ni, fifo_en_i, wr_i, rd_i, ovr_clr_i;
  logic [7:0]    wr_data_i;
  logic          wr_frm_i, wr_par_i, wr_brk_i;
  logic [10:0]   rd_word_o;
  logic          empty_o, full_o, overrun_o, ovr_evt_o;
  logic [CW-1:0] level_o;

  always #5 clk_i = ~clk_i;

  uart_rx_queue #(.DEPTH(DEPTH)) i_uart_rx_queue (.*);

  logic [10:0] sb_q[$];
  logic        exp_ovr;
  int          vec_cnt = 0;
  int          err_cnt = 0;
  bit          done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vec_cnt++;
    if (act !== exp) begin
      err_cnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver + model: one call = one clock cycle, entered at a negedge
  task automatic step(input bit wr, input logic [10:0] w, input bit rd,
                      input bit en, input bit clr);
    bit hit, pop, push;
    wr_i = wr; {wr_brk_i, wr_par_i, wr_frm_i, wr_data_i} = w;
    rd_i = rd; fifo_en_i = en; ovr_clr_i = clr;
    hit  = wr && (en ? (sb_q.size() == DEPTH) : (sb_q.size() >= 1));
    pop  = rd && (sb_q.size() > 0);
    push = wr && (sb_q.size() < DEPTH);
    #1;
    if (sb_q.size() > 0) chk("R2 head entry", rd_word_o, sb_q[0]);
    else                 chk("R8 empty word", rd_word_o, 0);
    @(posedge clk_i); #1;
    wr_i = 0; rd_i = 0; ovr_clr_i = 0;
    if (pop)  void'(sb_q.pop_front());
    if (push) sb_q.push_back(w);
    if (clr) exp_ovr = 0; else if (hit) exp_ovr = 1;
    @(negedge clk_i);
    // monitor side
    chk("R7 level", level_o, sb_q.size());
    chk("R5 overrun", overrun_o, exp_ovr);
    chk("R6 event", ovr_evt_o, hit);
    chk(en ? "R3 full" : "R4 full", full_o,
        en ? (sb_q.size() == DEPTH) : (sb_q.size() >= 1));
    chk("R8 empty", empty_o, sb_q.size() == 0);
  endtask

  function automatic logic [10:0] mk(input int i);
    return {3'(i % 8), 8'(i * 37 + 5)};
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      err_cnt++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
      $finish;
    end
  end

  initial begin
    rst_ni = 0; fifo_en_i = 1; wr_i = 0; rd_i = 0; ovr_clr_i = 0;
    wr_data_i = 0; wr_frm_i = 0; wr_par_i = 0; wr_brk_i = 0;
    exp_ovr = 0;
    repeat (3) @(negedge clk_i);
    chk("R1 level", level_o, 0);
    chk("R1 empty", empty_o, 1);
    chk("R1 full", full_o, 0);
    chk("R1 overrun", overrun_o, 0);
    chk("R1 event", ovr_evt_o, 0);
    rst_ni = 1;
    @(negedge clk_i);

    // R2/R3: fill to the limit in queue mode
    for (int i = 0; i < DEPTH; i++) step(1, mk(i), 0, 1, 0);
    step(1, 11'h7AA, 0, 1, 0);           // R3 discarded overrun
    step(0, 0, 0, 1, 0);                 // R5 sticky
    step(1, 11'h155, 1, 1, 0);           // R3 read+write at limit: write lost
    for (int i = 0; i < 4; i++) step(0, 0, 1, 1, 0);
    step(1, mk(40), 1, 1, 0);            // R7 same-cycle read and write
    step(1, mk(41), 1, 1, 0);
    step(0, 0, 0, 1, 1);                 // R5 clear
    while (sb_q.size() < DEPTH) step(1, mk(50 + sb_q.size()), 0, 1, 0);
    step(1, 11'h0F0, 0, 1, 1);           // R5 clear beats set, R6 still pulses
    while (sb_q.size() > 0) step(0, 0, 1, 1, 0);   // R2 order
    step(0, 0, 1, 1, 0);                 // R8 read while empty
    step(1, 11'h123, 1, 1, 0);           // R8 read while empty with write

    // R4: holding-register mode
    step(0, 0, 1, 0, 0);
    step(1, 11'h4C3, 0, 0, 0);
    step(1, 11'h23C, 0, 0, 0);           // R4 overrun, byte still stored
    step(0, 0, 1, 0, 0);
    step(0, 0, 1, 0, 0);                 // R4 excess must be drained
    step(0, 0, 0, 0, 1);
    step(1, 11'h011, 0, 0, 0);
    step(0, 0, 1, 0, 0);
    step(1, 11'h622, 0, 0, 0);
    step(1, 11'h733, 1, 0, 0);           // R4 write while held, read same cycle
    while (sb_q.size() > 0) step(0, 0, 1, 0, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end
endmodule